// File: doc/BRIEF.md
# Handshaked Registered Bidirectional Transceiver with Parity

This block moves bytes between two ports through a pair of independent holding registers. The forward register takes a word from port A and presents it on port B. The return register takes a word from port B, together with a parity bit that arrives with it, and presents it on port A. Each direction has its own load strobe and active-low load enable. Each also has an active-low output enable that turns on that direction's drivers. Each direction also keeps a status flag.

A direction's status flag rises when its register is loaded. It falls when the reader releases its output enable, which the block treats as the acknowledgement that the word has been read. A writer can therefore poll the flag for demand-response transfers.

On the forward path the block generates an even-count parity bit from the held word. On the return path it checks the stored word against the received parity bit and reports an active-low error. Every three-state pad is modelled as a data vector paired with a drive-enable. Everything runs in one clock domain. The load strobes are synchronous pulses, and a registered copy of each output enable is used to detect its release.

Top module: `xfer_parity_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both data registers, the stored parity bit and both flags. After reset, b_out and a_out read 0 and both flags read 0.
- R2: The forward register captures a_in on a clock edge where r_stb is 1 and r_load_n is 0. The new value shows on b_out from the next cycle. On any other edge, including r_stb=1 with r_load_n=1, b_out keeps its value.
- R3: The return register captures b_in on a clock edge where s_stb is 1 and s_load_n is 0. In the same edge it captures par_in into a one-bit store. On any other edge both keep their values.
- R4: A load of a direction sets that direction's flag (r_flag or s_flag) to 1 from the next cycle. Without a load or a release, the flag holds its value.
- R5: A release is an edge where the direction's output enable is 1 and was 0 at the previous edge. A release with no load clears that direction's flag from the next cycle.
- R6: When a load and a release of the same direction fall on one edge, the flag ends at 1.
- R7: b_drv and par_drv equal the inverse of r_oe_n. a_drv equals the inverse of s_oe_n. These follow combinationally, in the same cycle.
- R8: par_out is 1 when the forward register holds an even number of ones, including zero ones. It is 0 when the count is odd.
- R9: While s_oe_n is 0, err_n is 1 when the stored return word plus its stored parity bit hold an odd number of ones. It is 0 when that count is even.
- R10: While s_oe_n is 1, err_n is 1 whatever the return register holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | DATA_W | Word arriving from port A |
| r_stb | input | 1 | Forward register load strobe |
| r_load_n | input | 1 | Forward register load enable, active low |
| r_oe_n | input | 1 | Forward output enable and read acknowledge, active low |
| b_in | input | DATA_W | Word arriving from port B |
| par_in | input | 1 | Parity bit arriving with b_in |
| s_stb | input | 1 | Return register load strobe |
| s_load_n | input | 1 | Return register load enable, active low |
| s_oe_n | input | 1 | Return output enable and read acknowledge, active low |
| b_out | output | DATA_W | Forward register value for port B pads |
| b_drv | output | 1 | Drive enable for port B pads |
| par_out | output | 1 | Generated parity for the parity pad |
| par_drv | output | 1 | Drive enable for the parity pad |
| a_out | output | DATA_W | Return register value for port A pads |
| a_drv | output | 1 | Drive enable for port A pads |
| err_n | output | 1 | Parity error on the return path, active low |
| r_flag | output | 1 | Forward word waiting |
| s_flag | output | 1 | Return word waiting |

## Verification
The bench drives a load and a release of the same direction on one edge. A design that gave the release priority would drop a flag while a fresh word is still unread. It also holds r_stb high with r_load_n high, where a design that ignores the enable would overwrite the held word. It loads all-zero and odd-weight words to catch a parity output with the wrong sense. It flips the received parity bit under both settings of s_oe_n, so an error output that is not gated by the enable, or that has the wrong sense, shows up. Long runs with an output enable held low or held high confirm that only a low-to-high change clears a flag; a design that cleared on the level would fail there.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int DATA_W = 8;

    // Idle level of an active-low output enable
    localparam logic OE_IDLE = 1'b1;

    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_op_e;

    // Flag action chosen for one edge: a load outranks a release
    function automatic flag_op_e pick_flag_op(input logic load, input logic release_edge);
        if (load)
            return FLAG_SET;
        else if (release_edge)
            return FLAG_CLEAR;
        return FLAG_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_parity.sv
module xcvr_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] word,
    output logic         even
);
    logic [W:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ word[i];
    end

    assign even = ~chain[W];
endmodule

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic         stb,
    input  logic         load_n,
    input  logic         oe_n,
    output logic [W-1:0] q,
    output logic         flag
);
    logic     load;
    logic     oe_q;
    logic     release_edge;
    flag_op_e op;

    assign load         = stb & ~load_n;
    assign release_edge = oe_n & ~oe_q;
    assign op           = pick_flag_op(load, release_edge);

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            oe_q <= OE_IDLE;
            flag <= 1'b0;
        end else begin
            oe_q <= oe_n;
            if (load)
                q <= d;
            unique case (op)
                FLAG_SET:   flag <= 1'b1;
                FLAG_CLEAR: flag <= 1'b0;
                default:    flag <= flag;
            endcase
        end
    end
endmodule

// File: rtl/xfer_parity_xcvr.sv
module xfer_parity_xcvr
    import xcvr_pkg::*;
#(
    parameter int DATA_W = xcvr_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    input  logic              r_stb,
    input  logic              r_load_n,
    input  logic              r_oe_n,
    input  logic [DATA_W-1:0] b_in,
    input  logic              par_in,
    input  logic              s_stb,
    input  logic              s_load_n,
    input  logic              s_oe_n,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drv,
    output logic              par_out,
    output logic              par_drv,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drv,
    output logic              err_n,
    output logic              r_flag,
    output logic              s_flag
);
    localparam int SW = DATA_W + 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par;
    } ret_word_t;

    logic [DATA_W-1:0] fwd_q;
    ret_word_t         ret_d;
    ret_word_t         ret_q;
    logic              fwd_even;
    logic              ret_even;

    assign ret_d.data = b_in;
    assign ret_d.par  = par_in;

    xcvr_hold_reg #(.W(DATA_W)) u_fwd (
        .clk    (clk),
        .rst    (rst),
        .d      (a_in),
        .stb    (r_stb),
        .load_n (r_load_n),
        .oe_n   (r_oe_n),
        .q      (fwd_q),
        .flag   (r_flag)
    );

    xcvr_hold_reg #(.W(SW)) u_ret (
        .clk    (clk),
        .rst    (rst),
        .d      (ret_d),
        .stb    (s_stb),
        .load_n (s_load_n),
        .oe_n   (s_oe_n),
        .q      (ret_q),
        .flag   (s_flag)
    );

    xcvr_parity #(.W(DATA_W)) u_gen (
        .word (fwd_q),
        .even (fwd_even)
    );

    xcvr_parity #(.W(SW)) u_chk (
        .word (ret_q),
        .even (ret_even)
    );

    assign b_out   = fwd_q;
    assign b_drv   = ~r_oe_n;
    assign par_out = fwd_even;
    assign par_drv = ~r_oe_n;
    assign a_out   = ret_q.data;
    assign a_drv   = ~s_oe_n;
    // odd total count means the word arrived intact
    assign err_n   = s_oe_n | ~ret_even;
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              r_stb,
    input logic              r_load_n,
    input logic              r_oe_n,
    input logic              s_stb,
    input logic              s_load_n,
    input logic              s_oe_n,
    input logic [DATA_W-1:0] b_out,
    input logic              b_drv,
    input logic              par_out,
    input logic              par_drv,
    input logic              a_drv,
    input logic              err_n,
    input logic              r_flag,
    input logic              s_flag
);
    assert_fwd_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(r_stb && !r_load_n) |=> $stable(b_out));

    assert_rflag_set_R4: assert property (@(posedge clk) disable iff (rst)
        (r_stb && !r_load_n) |=> r_flag);

    assert_sflag_set_R4: assert property (@(posedge clk) disable iff (rst)
        (s_stb && !s_load_n) |=> s_flag);

    assert_rflag_clear_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(r_oe_n) && !(r_stb && !r_load_n)) |=> !r_flag);

    assert_sflag_clear_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(s_oe_n) && !(s_stb && !s_load_n)) |=> !s_flag);

    assert_rflag_noclear_R6: assert property (@(posedge clk) disable iff (rst)
        (!r_oe_n && !$rose(r_stb && !r_load_n) && !(r_stb && !r_load_n) && r_flag) |=> r_flag);

    assert_drive_R7: assert property (@(posedge clk) disable iff (rst)
        (b_drv == !r_oe_n) && (par_drv == b_drv) && (a_drv == !s_oe_n));

    assert_parity_R8: assert property (@(posedge clk) disable iff (rst)
        par_drv |-> (par_out == ($countones(b_out) % 2 == 0)));

    assert_err_idle_R10: assert property (@(posedge clk) disable iff (rst)
        s_oe_n |-> err_n);
endmodule

bind xfer_parity_xcvr xcvr_checker #(.DATA_W(DATA_W)) u_xcvr_checker (
    .clk      (clk),
    .rst      (rst),
    .r_stb    (r_stb),
    .r_load_n (r_load_n),
    .r_oe_n   (r_oe_n),
    .s_stb    (s_stb),
    .s_load_n (s_load_n),
    .s_oe_n   (s_oe_n),
    .b_out    (b_out),
    .b_drv    (b_drv),
    .par_out  (par_out),
    .par_drv  (par_drv),
    .a_drv    (a_drv),
    .err_n    (err_n),
    .r_flag   (r_flag),
    .s_flag   (s_flag)
);

// File: tb/xfer_parity_xcvr_bench.sv
module xfer_parity_xcvr_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         r_stb, r_load_n, r_oe_n;
    logic         par_in, s_stb, s_load_n, s_oe_n;
    logic [W-1:0] b_out, a_out;
    logic         b_drv, par_out, par_drv, a_drv, err_n, r_flag, s_flag;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    int m_r, m_s, m_sp, m_rf, m_sf, m_rprev, m_sprev;

    xfer_parity_xcvr #(.DATA_W(W)) u_xfer_parity_xcvr (
        .clk(clk), .rst(rst), .a_in(a_in), .r_stb(r_stb), .r_load_n(r_load_n),
        .r_oe_n(r_oe_n), .b_in(b_in), .par_in(par_in), .s_stb(s_stb),
        .s_load_n(s_load_n), .s_oe_n(s_oe_n), .b_out(b_out), .b_drv(b_drv),
        .par_out(par_out), .par_drv(par_drv), .a_out(a_out), .a_drv(a_drv),
        .err_n(err_n), .r_flag(r_flag), .s_flag(s_flag)
    );

    always #10 clk = ~clk;

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < W; i++) if ((v >> i) & 1) n++;
        return n;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output with the reference model
    task automatic compare();
        chk("R2 b_out", b_out, m_r);
        chk("R3 a_out", a_out, m_s);
        chk("R4/R5 r_flag", r_flag, m_rf);
        chk("R4/R5 s_flag", s_flag, m_sf);
        chk("R7 b_drv", b_drv, !r_oe_n);
        chk("R7 par_drv", par_drv, !r_oe_n);
        chk("R7 a_drv", a_drv, !s_oe_n);
        chk("R8 par_out", par_out, (ones(m_r) % 2 == 0) ? 1 : 0);
        if (s_oe_n) chk("R10 err_n", err_n, 1);
        else        chk("R9 err_n", err_n, ((ones(m_s) + m_sp) % 2 == 1) ? 1 : 0);
    endtask

    task automatic model_edge();
        if (rst) begin
            m_r = 0; m_s = 0; m_sp = 0; m_rf = 0; m_sf = 0; m_rprev = 1; m_sprev = 1;
        end else begin
            if (r_stb && !r_load_n) begin m_r = a_in; m_rf = 1; end
            else if (r_oe_n && !m_rprev) m_rf = 0;
            if (s_stb && !s_load_n) begin m_s = b_in; m_sp = par_in; m_sf = 1; end
            else if (s_oe_n && !m_sprev) m_sf = 0;
            m_rprev = r_oe_n;
            m_sprev = s_oe_n;
        end
    endtask

    // drive one cycle of inputs, check outputs, then let the edge happen
    task automatic cyc(input logic rr, input logic [W-1:0] a, input logic rs, input logic rl,
                       input logic ro, input logic [W-1:0] b, input logic p,
                       input logic ss, input logic sl, input logic so);
        @(negedge clk);
        rst = rr; a_in = a; r_stb = rs; r_load_n = rl; r_oe_n = ro;
        b_in = b; par_in = p; s_stb = ss; s_load_n = sl; s_oe_n = so;
        #1;
        if (!rr) compare();
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle(input logic ro, input logic so);
        cyc(0, 8'h00, 0, 1, ro, 8'h00, 0, 0, 1, so);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_rprev = 1; m_sprev = 1;
        m_r = 0; m_s = 0; m_sp = 0; m_rf = 0; m_sf = 0;
        cyc(1, 8'hFF, 1, 0, 1, 8'hFF, 1, 1, 0, 1);
        cyc(1, 8'hFF, 1, 0, 1, 8'hFF, 1, 1, 0, 1);
        @(negedge clk); rst = 0; r_stb = 0; s_stb = 0; #1;
        // R1: state after reset
        chk("R1 b_out", b_out, 0);
        chk("R1 a_out", a_out, 0);
        chk("R1 r_flag", r_flag, 0);
        chk("R1 s_flag", s_flag, 0);
        @(posedge clk); model_edge();

        // R8: all zeros gives parity 1
        cyc(0, 8'h00, 1, 0, 1, 8'h00, 0, 0, 1, 1);
        idle(0, 1);
        @(negedge clk); #1; chk("R8 zero word parity", par_out, 1);
        @(posedge clk); model_edge();
        idle(1, 1); // release clears R5
        idle(1, 1);
        @(negedge clk); #1; chk("R5 flag cleared by release", r_flag, 0);
        @(posedge clk); model_edge();

        // R8 odd and even weights
        cyc(0, 8'h07, 1, 0, 0, 8'h00, 0, 0, 1, 1);
        idle(0, 1);
        @(negedge clk); #1; chk("R8 odd word parity", par_out, 0);
        @(posedge clk); model_edge();
        cyc(0, 8'hA5, 1, 0, 0, 8'h00, 0, 0, 1, 1);
        idle(0, 1);

        // R2: strobe with enable high is ignored
        cyc(0, 8'h3C, 1, 1, 0, 8'h00, 0, 0, 1, 1);
        idle(0, 1);
        @(negedge clk); #1; chk("R2 ignored load keeps word", b_out, 8'hA5);
        @(posedge clk); model_edge();

        // R6: load and release on the same edge
        cyc(0, 8'h5A, 1, 0, 1, 8'h00, 0, 0, 1, 1);
        idle(1, 1);
        @(negedge clk); #1; chk("R6 load beats release", r_flag, 1);
        @(posedge clk); model_edge();

        // R9/R10 on the return path
        cyc(0, 8'h00, 0, 1, 1, 8'h03, 0, 1, 0, 0);
        idle(1, 0);
        @(negedge clk); #1; chk("R9 even total flags error", err_n, 0);
        @(posedge clk); model_edge();
        idle(1, 1);
        @(negedge clk); #1; chk("R10 disabled error high", err_n, 1);
        @(posedge clk); model_edge();
        cyc(0, 8'h00, 0, 1, 1, 8'h03, 1, 1, 0, 0);
        idle(1, 0);
        @(negedge clk); #1; chk("R9 odd total no error", err_n, 1);
        chk("R3 return word", a_out, 8'h03);
        @(posedge clk); model_edge();
        idle(1, 1);
        idle(1, 1);
        @(negedge clk); #1; chk("R5 s_flag cleared", s_flag, 0);
        @(posedge clk); model_edge();

        // mixed traffic
        for (int k = 0; k < 600; k++) begin
            cyc(0, W'($urandom), 1'($urandom), 1'($urandom), 1'(($urandom % 4) != 0),
                W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'(($urandom % 4) != 0));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule